// File: doc/BRIEF.md
# Bus Master Security Filter

This block is placed between a bus-mastering device, for example a DMA engine, and the downstream interconnect. It decides whether each transaction from that master may proceed. Two static pins set it up. One pin says whether the master is non-secure. The other pin chooses what happens to a refused access: it either ends with a bus error, or it completes quietly, with reads returning zero and writes discarded. There are no programmable registers.

The upstream side uses a valid/ready request channel carrying address, write flag and write data. Responses come back as a one-cycle pulse carrying read data and an error flag. For every request offered, the block drives the address onto an external combinational attribution port and reads back a secure flag. A non-secure master that targets a secure address is refused. Every other transaction is passed downstream unchanged. A forwarded transaction carries the master's configured security state on a separate attribute pin.

Each refusal sets a sticky interrupt, which a clear pin removes. Only one transaction is in flight at a time.

Top module: `secGateTop`

## Requirements
- R1: During and immediately after reset the block drives `irq`=0, `upReady`=1, `dnValid`=0 and `upRspValid`=0.
- R2: `attrAddr` always equals `upAddr`. A request accepted with `cfgMasterNs`=1 and `attrSecure`=1 is refused. Every other combination is forwarded on `dnValid`.
- R3: A forwarded request keeps its address, write flag and write data unchanged on `dnAddr`, `dnWrite` and `dnWdata`. These values and `dnValid` stay stable from the cycle after acceptance until the cycle in which `dnReady` is high.
- R4: Once the downstream handshake has completed, a `dnRspValid` pulse is copied to the upstream side in the next cycle. `upRspValid` pulses for one cycle, carrying the same `upRdata` and `upRspErr` values.
- R5: A refused request with `cfgErrOnBlock`=1 produces `upRspValid` in the cycle after acceptance, with `upRspErr`=1 and `upRdata`=0.
- R6: A refused request with `cfgErrOnBlock`=0 produces `upRspValid` in the cycle after acceptance, with `upRspErr`=0 and `upRdata`=0. The request never appears on `dnValid`, whether it is a read or a write.
- R7: `irq` goes to 1 in the cycle after a refused acceptance and stays at 1 until it is cleared.
- R8: `irqClr`=1 in a cycle with no refused acceptance makes `irq` 0 in the next cycle. If a refusal is accepted in the same cycle as `irqClr`=1, `irq` stays at 1.
- R9: `upReady` is 1 only when no transaction is outstanding. It falls after an acceptance and returns in the cycle after the `upRspValid` pulse.
- R10: `dnNs` equals the value of `cfgMasterNs` at acceptance. The refusal response type follows `cfgErrOnBlock` at acceptance. Later changes to either pin do not affect a transaction that is already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMasterNs | input | 1 | 1: master is non-secure; 0: master is secure |
| cfgErrOnBlock | input | 1 | 1: refused access returns error; 0: read-zero/write-discard |
| irqClr | input | 1 | Clears the sticky refusal interrupt |
| irq | output | 1 | Sticky refusal interrupt |
| upValid | input | 1 | Upstream request valid |
| upReady | output | 1 | Upstream request accepted when high with upValid |
| upAddr | input | ADDR_W | Upstream request address |
| upWrite | input | 1 | Upstream request is a write |
| upWdata | input | DATA_W | Upstream write data |
| upRspValid | output | 1 | One-cycle upstream response pulse |
| upRdata | output | DATA_W | Upstream read data |
| upRspErr | output | 1 | Upstream error response |
| attrAddr | output | ADDR_W | Address sent to the attribution lookup |
| attrSecure | input | 1 | Lookup result: 1 when the address is secure |
| dnValid | output | 1 | Downstream request valid |
| dnReady | input | 1 | Downstream request accepted |
| dnAddr | output | ADDR_W | Downstream address |
| dnWrite | output | 1 | Downstream write flag |
| dnWdata | output | DATA_W | Downstream write data |
| dnNs | output | 1 | Downstream security attribute (1 = non-secure) |
| dnRspValid | input | 1 | Downstream response pulse |
| dnRdata | input | DATA_W | Downstream read data |
| dnRspErr | input | 1 | Downstream error flag |

## Verification
Two events can land in the same cycle: a refusal being accepted, and software clearing the interrupt. The bench holds `irqClr` high across the whole of a refused request. The acceptance edge therefore sees both events, and the cycle after it sees only the clear. The reference model expects `irq` to stay at 1 after the first edge and to drop after the second. The bench also changes the configuration pins while a forwarded request is stalled on `dnReady`, and expects `dnNs` to keep the value captured at acceptance.

// File: rtl/secGatePkg.sv
package secGatePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } gateState_t;

  typedef struct packed {
    logic loadReq;    // capture a forwarded request
    logic loadBlock;  // build a local response for a refused request
    logic loadDn;     // capture the downstream response
  } gateStrobe_t;

endpackage

// File: rtl/secGateCtrl.sv
module secGateCtrl
  import secGatePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        upValid,
  input  logic        cfgMasterNs,
  input  logic        attrSecure,
  input  logic        irqClr,
  input  logic        dnReady,
  input  logic        dnRspValid,
  output logic        upReady,
  output logic        dnValid,
  output logic        upRspValid,
  output logic        irq,
  output gateStrobe_t strobe
);

  gateState_t state, stateNext;
  logic accept;
  logic blockHit;

  always_comb begin
    accept   = upValid && (state == ST_IDLE);
    blockHit = cfgMasterNs && attrSecure;
    strobe.loadReq   = accept && !blockHit;
    strobe.loadBlock = accept && blockHit;
    strobe.loadDn    = (state == ST_WAIT) && dnRspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (strobe.loadBlock)    stateNext = ST_RSP;
        else if (strobe.loadReq) stateNext = ST_FWD;
      end
      ST_FWD:  if (dnReady)      stateNext = ST_WAIT;
      ST_WAIT: if (dnRspValid)   stateNext = ST_RSP;
      ST_RSP:                    stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // sticky flag: a new refusal takes priority over a clear
  always_ff @(posedge clk) begin
    if (!rstN)                 irq <= 1'b0;
    else if (strobe.loadBlock) irq <= 1'b1;
    else if (irqClr)           irq <= 1'b0;
  end

  assign upReady    = (state == ST_IDLE);
  assign dnValid    = (state == ST_FWD);
  assign upRspValid = (state == ST_RSP);

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBlock |=> irq); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !strobe.loadBlock) |=> !irq); // R8
  AST_SINGLE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upReady) |=> !upReady); // R9
  AST_BLOCK_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBlock |=> (upRspValid && !dnValid)); // R6

endmodule

// File: rtl/secGateDp.sv
module secGateDp
  import secGatePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic              upWrite,
  input  logic [DATA_W-1:0] upWdata,
  input  logic              cfgMasterNs,
  input  logic              cfgErrOnBlock,
  input  logic [DATA_W-1:0] dnRdata,
  input  logic              dnRspErr,
  output logic [ADDR_W-1:0] attrAddr,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  output logic              dnNs,
  output logic [DATA_W-1:0] upRdata,
  output logic              upRspErr
);

  localparam logic [DATA_W-1:0] ZERO_DATA = '0;

  assign attrAddr = upAddr;

  // request hold registers, security attribute fixed at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dnAddr  <= '0;
      dnWrite <= 1'b0;
      dnWdata <= '0;
      dnNs    <= 1'b0;
    end else if (strobe.loadReq) begin
      dnAddr  <= upAddr;
      dnWrite <= upWrite;
      dnWdata <= upWdata;
      dnNs    <= cfgMasterNs;
    end
  end

  // response registers: local zero response or captured downstream reply
  always_ff @(posedge clk) begin
    if (!rstN) begin
      upRdata  <= ZERO_DATA;
      upRspErr <= 1'b0;
    end else if (strobe.loadBlock) begin
      upRdata  <= ZERO_DATA;
      upRspErr <= cfgErrOnBlock;
    end else if (strobe.loadDn) begin
      upRdata  <= dnRdata;
      upRspErr <= dnRspErr;
    end
  end

  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBlock |=> (upRdata == ZERO_DATA)); // R5
  AST_PASS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDn |=> (upRdata == $past(dnRdata) && upRspErr == $past(dnRspErr))); // R4
  AST_NS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadReq |=> (dnNs == $past(cfgMasterNs))); // R10

endmodule

// File: rtl/secGateTop.sv
module secGateTop
  import secGatePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMasterNs,
  input  logic              cfgErrOnBlock,
  input  logic              irqClr,
  output logic              irq,
  input  logic              upValid,
  output logic              upReady,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic              upWrite,
  input  logic [DATA_W-1:0] upWdata,
  output logic              upRspValid,
  output logic [DATA_W-1:0] upRdata,
  output logic              upRspErr,
  output logic [ADDR_W-1:0] attrAddr,
  input  logic              attrSecure,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  output logic              dnNs,
  input  logic              dnRspValid,
  input  logic [DATA_W-1:0] dnRdata,
  input  logic              dnRspErr
);

  gateStrobe_t strobe;

  secGateCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .upValid    (upValid),
    .cfgMasterNs(cfgMasterNs),
    .attrSecure (attrSecure),
    .irqClr     (irqClr),
    .dnReady    (dnReady),
    .dnRspValid (dnRspValid),
    .upReady    (upReady),
    .dnValid    (dnValid),
    .upRspValid (upRspValid),
    .irq        (irq),
    .strobe     (strobe)
  );

  secGateDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .upAddr       (upAddr),
    .upWrite      (upWrite),
    .upWdata      (upWdata),
    .cfgMasterNs  (cfgMasterNs),
    .cfgErrOnBlock(cfgErrOnBlock),
    .dnRdata      (dnRdata),
    .dnRspErr     (dnRspErr),
    .attrAddr     (attrAddr),
    .dnAddr       (dnAddr),
    .dnWrite      (dnWrite),
    .dnWdata      (dnWdata),
    .dnNs         (dnNs),
    .upRdata      (upRdata),
    .upRspErr     (upRspErr)
  );

  AST_DN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnReady) |=> (dnValid && $stable(dnAddr) && $stable(dnWdata) && $stable(dnNs))); // R3

endmodule

// File: tb/test_secGateTop.sv
`timescale 1ns/1ps
module test_secGateTop;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgNs = 1'b0, cfgErr = 1'b0, irqClr = 1'b0;
  logic upValid = 1'b0, upWrite = 1'b0;
  logic [AW-1:0] upAddr = '0;
  logic [DW-1:0] upWdata = '0;
  logic dnReady = 1'b0, dnRspValid = 1'b0, dnRspErr = 1'b0;
  logic [DW-1:0] dnRdata = '0;
  logic attrSecure;
  logic irq, upReady, upRspValid, upRspErr, dnValid, dnWrite, dnNs;
  logic [DW-1:0] upRdata, dnWdata;
  logic [AW-1:0] attrAddr, dnAddr;

  always #2 clk = ~clk;

  // external attribution lookup: top address bit marks secure space
  assign attrSecure = attrAddr[AW-1];

  secGateTop #(.ADDR_W(AW), .DATA_W(DW)) i_secGateTop (
    .clk(clk), .rstN(rstN), .cfgMasterNs(cfgNs), .cfgErrOnBlock(cfgErr),
    .irqClr(irqClr), .irq(irq), .upValid(upValid), .upReady(upReady),
    .upAddr(upAddr), .upWrite(upWrite), .upWdata(upWdata),
    .upRspValid(upRspValid), .upRdata(upRdata), .upRspErr(upRspErr),
    .attrAddr(attrAddr), .attrSecure(attrSecure), .dnValid(dnValid),
    .dnReady(dnReady), .dnAddr(dnAddr), .dnWrite(dnWrite), .dnWdata(dnWdata),
    .dnNs(dnNs), .dnRspValid(dnRspValid), .dnRdata(dnRdata), .dnRspErr(dnRspErr)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // behavioural reference model: phase 0 idle, 1 offered, 2 awaiting reply, 3 replying
  int mPhase = 0, mSrc = 0;
  logic [AW-1:0] mAddr = '0;
  logic mWrite = 0, mNs = 0, mRspErr = 0, mIrq = 0;
  logic [DW-1:0] mWdata = '0, mRspData = '0;
  bit accFlag = 0;
  int readyDelay = 0, rspDelay = 0, rdyCnt = 0, rspCnt = 0;
  logic dnErrMode = 0;

  always @(posedge clk) begin
    bit blk;
    cyc++;
    accFlag = 0;
    blk = 0;
    if (!rstN) begin
      mPhase = 0; mIrq = 0;
    end else begin
      case (mPhase)
        0: if (upValid) begin
          accFlag = 1;
          if (cfgNs && upAddr[AW-1]) begin
            blk = 1; mRspData = '0; mRspErr = cfgErr; mSrc = cfgErr ? 1 : 2; mPhase = 3;
          end else begin
            mAddr = upAddr; mWrite = upWrite; mWdata = upWdata; mNs = cfgNs; mSrc = 0; mPhase = 1;
          end
        end
        1: if (dnReady) mPhase = 2;
        2: if (dnRspValid) begin mRspData = dnRdata; mRspErr = dnRspErr; mPhase = 3; end
        default: mPhase = 0;
      endcase
      if (blk) mIrq = 1;
      else if (irqClr) mIrq = 0;
    end
    if (cyc > WD_LIMIT && !done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      report;
      $finish;
    end
  end

  // compare every cycle away from the edge, then drive the downstream side
  always @(negedge clk) begin
    string rspTag;
    if (rstN) begin
      chk(upReady === (mPhase == 0), "R9 upReady", upReady, mPhase == 0);
      chk(dnValid === (mPhase == 1), "R2 R6 dnValid", dnValid, mPhase == 1);
      chk(upRspValid === (mPhase == 3), "R4 R5 R6 upRspValid", upRspValid, mPhase == 3);
      chk(irq === mIrq, "R7 R8 irq", irq, mIrq);
      chk(attrAddr === upAddr, "R2 attrAddr", attrAddr, upAddr);
      if (mPhase == 1) begin
        chk(dnAddr === mAddr, "R3 dnAddr", dnAddr, mAddr);
        chk(dnWrite === mWrite, "R3 dnWrite", dnWrite, mWrite);
        chk(dnWdata === mWdata, "R3 dnWdata", dnWdata, mWdata);
        chk(dnNs === mNs, "R10 dnNs", dnNs, mNs);
      end
      if (mPhase == 3) begin
        rspTag = (mSrc == 0) ? "R4 response" : (mSrc == 1) ? "R5 response" : "R6 response";
        chk(upRdata === mRspData, rspTag, upRdata, mRspData);
        chk(upRspErr === mRspErr, rspTag, upRspErr, mRspErr);
      end
    end
    if (mPhase == 1) begin dnReady = (rdyCnt >= readyDelay); rdyCnt++; end
    else begin dnReady = 0; rdyCnt = 0; end
    if (mPhase == 2) begin
      dnRspValid = (rspCnt >= rspDelay);
      dnRdata = mAddr ^ 32'hC3A5_5A3C;
      dnRspErr = dnErrMode;
      rspCnt++;
    end else begin dnRspValid = 0; rspCnt = 0; end
  end

  task automatic issue(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d, input bit flip);
    @(negedge clk);
    upValid = 1; upAddr = a; upWrite = w; upWdata = d;
    do @(negedge clk); while (!accFlag);
    upValid = 0;
    if (flip) begin cfgNs = ~cfgNs; cfgErr = ~cfgErr; end
    while (mPhase != 0) @(negedge clk);
    if (flip) begin cfgNs = ~cfgNs; cfgErr = ~cfgErr; end
  endtask

  task automatic pulseClr;
    @(negedge clk); irqClr = 1;
    @(negedge clk); irqClr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(upReady === 1'b1, "R1 upReady", upReady, 1);
    chk(dnValid === 1'b0, "R1 dnValid", dnValid, 0);
    chk(upRspValid === 1'b0, "R1 upRspValid", upRspValid, 0);
    rstN = 1;
    @(negedge clk);
    chk(irq === 1'b0 && upReady === 1'b1, "R1 after release", {irq, upReady}, 2'b01);

    // secure master: everything forwarded (R2 R3 R4)
    cfgNs = 0;
    issue(32'h8000_0010, 1'b0, '0, 0);
    issue(32'h8000_0020, 1'b1, 32'h1234_5678, 0);
    readyDelay = 3; rspDelay = 2;
    issue(32'h0000_0040, 1'b1, 32'hDEAD_BEEF, 0);
    dnErrMode = 1;
    issue(32'h0000_0044, 1'b0, '0, 0);
    dnErrMode = 0; readyDelay = 0; rspDelay = 0;

    // non-secure master to non-secure space: forwarded with dnNs=1
    cfgNs = 1;
    issue(32'h0000_1000, 1'b0, '0, 0);

    // refused with error (R5 R7)
    cfgErr = 1;
    issue(32'h8000_2000, 1'b0, '0, 0);
    repeat (3) @(negedge clk);
    pulseClr;                                   // R8 plain clear
    @(negedge clk);

    // refused quietly, write and read (R6)
    cfgErr = 0;
    issue(32'h8000_3000, 1'b1, 32'hFFFF_FFFF, 0);
    issue(32'h8000_3004, 1'b0, '0, 0);
    pulseClr;

    // R8: clear held high over a refused acceptance
    @(negedge clk); irqClr = 1;
    issue(32'h8000_4000, 1'b0, '0, 0);
    @(negedge clk); irqClr = 0;
    repeat (2) @(negedge clk);

    // R10: pins change while a forwarded request is stalled
    readyDelay = 4; rspDelay = 1;
    issue(32'h0000_5000, 1'b1, 32'h0BAD_F00D, 1);
    cfgNs = 0;
    issue(32'h8000_5004, 1'b0, '0, 1);
    cfgNs = 1; cfgErr = 1;
    issue(32'h8000_5008, 1'b0, '0, 1);           // refused, error chosen at acceptance
    readyDelay = 0; rspDelay = 0;

    // back-to-back mixed traffic
    for (int i = 0; i < 8; i++) begin
      cfgErr = i[0];
      issue({i[1], 27'd0, i[2:0], 1'b0}, i[2], 32'h100 + i, 0);
    end
    repeat (4) @(negedge clk);
    done = 1;
    report;
    $finish;
  end

endmodule